// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block keeps the control-flow state of one warp in a SIMT pipeline. A warp is a group of threads that share one program counter. When a conditional branch splits the active threads between two targets, the block runs the two groups one after the other, each with its own subset mask. It then joins them again at a reconvergence PC, which an earlier stage supplies with the branch. The top entry of the stack gives the PC to fetch next and the mask of threads that may write results.

After each basic block the pipeline reports one event. The event is either a plain advance to a new PC or a branch. A branch event carries the per-thread taken bits, the taken target, the fall-through target and the reconvergence PC. Each stack entry holds a next PC, a reconvergence PC and a thread mask. When a divergent branch arrives, the top entry is parked at the reconvergence PC. Path entries are then pushed so that the taken group runs first. An entry is removed as soon as its PC reaches its own reconvergence PC, and execution continues with the wider mask of the entry below it. The stack depth is a parameter. A push that does not fit raises a sticky error flag and leaves the stack unchanged.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the fetch PC equals the START_PC parameter, the active mask is all ones, the overflow flag is 0, and the stack holds one base entry that is never popped.
- R2: A non-branch event (evValid=1, evBranch=0) sets the fetch PC to evPc and leaves the mask unchanged. The exception is the case where evPc equals the top entry's reconvergence PC above the base entry (see R5).
- R3: A branch where every active thread goes the same way pushes nothing. The fetch PC becomes brTakenPc if no active thread has a clear bit in brTakenMask, or brFallPc if no active thread has a set bit. Bits of brTakenMask for inactive threads are ignored, and the mask is unchanged.
- R4: On a divergent branch, the taken group runs first. The fetch PC becomes brTakenPc and the mask becomes (active mask AND brTakenMask).
- R5: When an event moves a path entry to its own reconvergence PC, that entry is popped. The entry below resumes with its own PC and mask. For a divergent branch, this is the fall-through group at brFallPc with mask (active AND NOT brTakenMask).
- R6: When both groups have reached the reconvergence PC, the fetch PC equals that PC and the full pre-branch mask is restored.
- R7: A path whose target equals brReconvPc is not pushed. Its threads wait at the join, so only one pop is needed before the join.
- R8: Divergences nest. An inner divergence restores its outer path's mask at its join, and the outer join then restores the original mask.
- R9: A divergence that needs more entries than the DEPTH-entry stack has free sets overflowErr. The flag stays set until reset, and the fetch PC and mask are left unchanged. A later push that fits still proceeds.
- R10: When evValid is 0, all other inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | An end-of-block event is present this cycle |
| evBranch | input | 1 | The event is a conditional branch |
| evPc | input | PC_W | Next PC for a non-branch event |
| brTakenMask | input | THREADS | Per-thread branch outcome, 1 = taken |
| brTakenPc | input | PC_W | Taken target |
| brFallPc | input | PC_W | Fall-through target |
| brReconvPc | input | PC_W | Reconvergence PC of the branch |
| fetchPc | output | PC_W | PC of the top entry, the next block to fetch |
| activeMask | output | THREADS | Thread mask of the top entry |
| overflowErr | output | 1 | Sticky stack overflow flag |

## Verification
Some properties are checked on every cycle. The active mask is never empty. A push never widens the mask. The base entry is never popped. The overflow flag never clears on its own, and an overflow leaves the top entry untouched. The exact PC and mask sequences need the directed scenarios. These cover taken-first ordering, the hand-over to the fall-through group, mask restoration at the join, the skipped empty path, nesting, and the exact point at which the stack runs out of room.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
  // Strobes from control to the stack storage
  typedef struct packed {
    logic popTop;
    logic setTop;
    logic pushFall;
    logic pushTaken;
    logic overflow;
  } ctlStrobes_t;
endpackage

// File: rtl/simt_stack_dp.sv
module simt_stack_dp
  import simt_stack_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int THREADS  = 32,
  parameter int DEPTH    = 8,
  parameter logic [PC_W-1:0] START_PC = '0,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  input  logic [PC_W-1:0]    newTopPc,
  input  logic [PC_W-1:0]    takenPc,
  input  logic [PC_W-1:0]    fallPc,
  input  logic [PC_W-1:0]    reconvPc,
  input  logic [THREADS-1:0] takenSub,
  input  logic [THREADS-1:0] fallSub,
  output logic [PC_W-1:0]    topNext,
  output logic [PC_W-1:0]    topReconv,
  output logic [THREADS-1:0] topMask,
  output logic [IDX_W-1:0]   topIdx
);
  logic [PC_W-1:0]    nextMem   [DEPTH];
  logic [PC_W-1:0]    reconvMem [DEPTH];
  logic [THREADS-1:0] maskMem   [DEPTH];
  logic [IDX_W-1:0]   fallSlot, takenSlot, pushCount;

  always_comb begin
    fallSlot  = topIdx + IDX_W'(1);
    takenSlot = topIdx + IDX_W'(1) + IDX_W'(strb.pushFall);
    pushCount = IDX_W'(strb.pushFall) + IDX_W'(strb.pushTaken);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topIdx       <= '0;
      nextMem[0]   <= START_PC;
      reconvMem[0] <= '1;
      maskMem[0]   <= '1;
    end else if (strb.popTop) begin
      topIdx <= topIdx - IDX_W'(1);
    end else begin
      if (strb.setTop) nextMem[topIdx] <= newTopPc;
      if (strb.pushFall) begin
        nextMem[fallSlot]   <= fallPc;
        reconvMem[fallSlot] <= reconvPc;
        maskMem[fallSlot]   <= fallSub;
      end
      if (strb.pushTaken) begin
        nextMem[takenSlot]   <= takenPc;
        reconvMem[takenSlot] <= reconvPc;
        maskMem[takenSlot]   <= takenSub;
      end
      topIdx <= topIdx + pushCount;
    end
  end

  assign topNext   = nextMem[topIdx];
  assign topReconv = reconvMem[topIdx];
  assign topMask   = maskMem[topIdx];

  // R1
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    topMask != '0);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.popTop |-> topIdx != '0);
  // R4
  push_narrows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushTaken || strb.pushFall) |=> (topMask & ~$past(topMask)) == '0);
  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.overflow |=> ($stable(topIdx) && $stable(topMask) && $stable(topNext)));
endmodule

// File: rtl/simt_stack_ctl.sv
module simt_stack_ctl
  import simt_stack_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int THREADS = 32,
  parameter int DEPTH   = 8,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evValid,
  input  logic               evBranch,
  input  logic [PC_W-1:0]    evPc,
  input  logic [THREADS-1:0] brTakenMask,
  input  logic [PC_W-1:0]    brTakenPc,
  input  logic [PC_W-1:0]    brFallPc,
  input  logic [PC_W-1:0]    brReconvPc,
  input  logic [PC_W-1:0]    topReconv,
  input  logic [THREADS-1:0] topMask,
  input  logic [IDX_W-1:0]   topIdx,
  output ctlStrobes_t        strb,
  output logic [PC_W-1:0]    newTopPc,
  output logic [THREADS-1:0] takenSub,
  output logic [THREADS-1:0] fallSub,
  output logic               overflowErr
);
  logic            divergent, needFall, needTaken;
  logic [PC_W-1:0] moveTarget;
  logic [IDX_W:0]  freeSlots, needCount;

  always_comb begin
    takenSub  = topMask & brTakenMask;
    fallSub   = topMask & ~brTakenMask;
    divergent = evBranch && (takenSub != '0) && (fallSub != '0) &&
                !((brTakenPc == brReconvPc) && (brFallPc == brReconvPc));
    needFall  = divergent && (brFallPc != brReconvPc);
    needTaken = divergent && (brTakenPc != brReconvPc);
    needCount = (IDX_W+1)'(needFall) + (IDX_W+1)'(needTaken);
    freeSlots = (IDX_W+1)'(DEPTH - 1) - {1'b0, topIdx};
    if (!evBranch)            moveTarget = evPc;
    else if (takenSub == '0)  moveTarget = brFallPc;
    else if (fallSub == '0)   moveTarget = brTakenPc;
    else                      moveTarget = brReconvPc;

    strb     = '0;
    newTopPc = moveTarget;
    if (evValid) begin
      if (divergent) begin
        if (needCount > freeSlots) begin
          strb.overflow = 1'b1;
        end else begin
          strb.setTop    = 1'b1;
          strb.pushFall  = needFall;
          strb.pushTaken = needTaken;
          newTopPc       = brReconvPc;
        end
      end else if ((topIdx != '0) && (moveTarget == topReconv)) begin
        strb.popTop = 1'b1;
      end else begin
        strb.setTop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              overflowErr <= 1'b0;
    else if (strb.overflow) overflowErr <= 1'b1;
  end

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evValid |-> (strb == '0));
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stack_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int THREADS = 32,
  parameter int DEPTH   = 8,
  parameter logic [PC_W-1:0] START_PC = 32'h100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evValid,
  input  logic               evBranch,
  input  logic [PC_W-1:0]    evPc,
  input  logic [THREADS-1:0] brTakenMask,
  input  logic [PC_W-1:0]    brTakenPc,
  input  logic [PC_W-1:0]    brFallPc,
  input  logic [PC_W-1:0]    brReconvPc,
  output logic [PC_W-1:0]    fetchPc,
  output logic [THREADS-1:0] activeMask,
  output logic               overflowErr
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctlStrobes_t        strb;
  logic [PC_W-1:0]    newTopPc, topReconv;
  logic [THREADS-1:0] takenSub, fallSub;
  logic [IDX_W-1:0]   topIdx;

  simt_stack_ctl #(.PC_W(PC_W), .THREADS(THREADS), .DEPTH(DEPTH)) i_ctl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evBranch(evBranch),
    .evPc(evPc), .brTakenMask(brTakenMask), .brTakenPc(brTakenPc),
    .brFallPc(brFallPc), .brReconvPc(brReconvPc), .topReconv(topReconv),
    .topMask(activeMask), .topIdx(topIdx), .strb(strb), .newTopPc(newTopPc),
    .takenSub(takenSub), .fallSub(fallSub), .overflowErr(overflowErr)
  );

  simt_stack_dp #(.PC_W(PC_W), .THREADS(THREADS), .DEPTH(DEPTH),
                  .START_PC(START_PC)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .newTopPc(newTopPc),
    .takenPc(brTakenPc), .fallPc(brFallPc), .reconvPc(brReconvPc),
    .takenSub(takenSub), .fallSub(fallSub), .topNext(fetchPc),
    .topReconv(topReconv), .topMask(activeMask), .topIdx(topIdx)
  );
endmodule

// File: tb/test_simt_reconv_stack.sv
module test_simt_reconv_stack;
  logic        clk = 1'b0;
  logic        rstN;
  logic        evValid, evBranch;
  logic [31:0] evPc, brTakenMask, brTakenPc, brFallPc, brReconvPc;
  logic [31:0] fetchPc, activeMask;
  logic        overflowErr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  simt_reconv_stack i_simt_reconv_stack (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evBranch(evBranch),
    .evPc(evPc), .brTakenMask(brTakenMask), .brTakenPc(brTakenPc),
    .brFallPc(brFallPc), .brReconvPc(brReconvPc), .fetchPc(fetchPc),
    .activeMask(activeMask), .overflowErr(overflowErr)
  );

  task automatic expect_state(string req, logic [31:0] pc, logic [31:0] m, logic ovf);
    checks++;
    if (fetchPc !== pc || activeMask !== m || overflowErr !== ovf) begin
      errors++;
      $display("FAIL %s: pc=%h mask=%h ovf=%b expected pc=%h mask=%h ovf=%b",
               req, fetchPc, activeMask, overflowErr, pc, m, ovf);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0; evValid = 1'b0; evBranch = 1'b0; evPc = '0;
    brTakenMask = '0; brTakenPc = '0; brFallPc = '0; brReconvPc = '0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic step_plain(logic [31:0] pc);
    evValid = 1'b1; evBranch = 1'b0; evPc = pc;
    @(negedge clk);
    evValid = 1'b0;
  endtask

  task automatic step_branch(logic [31:0] tm, logic [31:0] tp, logic [31:0] fp, logic [31:0] rp);
    evValid = 1'b1; evBranch = 1'b1; brTakenMask = tm;
    brTakenPc = tp; brFallPc = fp; brReconvPc = rp;
    @(negedge clk);
    evValid = 1'b0; evBranch = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_state("R1 reset", 32'h100, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_plain();
    step_plain(32'h104);
    expect_state("R2 plain advance", 32'h104, 32'hFFFF_FFFF, 1'b0);
    evPc = 32'h999; evBranch = 1'b1; brTakenMask = 32'h1;
    @(negedge clk); @(negedge clk);
    expect_state("R10 idle ignored", 32'h104, 32'hFFFF_FFFF, 1'b0);
    step_plain(32'hFFFF_FFFF);
    expect_state("R1 base entry never pops", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_uniform();
    step_branch(32'hFFFF_FFFF, 32'h200, 32'h108, 32'h300);
    expect_state("R3 all taken", 32'h200, 32'hFFFF_FFFF, 1'b0);
    step_branch(32'h0, 32'h280, 32'h208, 32'h300);
    expect_state("R3 none taken", 32'h208, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_diverge();
    step_branch(32'h0000_FFFF, 32'h400, 32'h500, 32'h600);
    expect_state("R4 taken first", 32'h400, 32'h0000_FFFF, 1'b0);
    step_branch(32'hFFFF_0000, 32'h480, 32'h410, 32'h600);
    expect_state("R3 inactive bits ignored", 32'h410, 32'h0000_FFFF, 1'b0);
    step_plain(32'h600);
    expect_state("R5 fall group resumes", 32'h500, 32'hFFFF_0000, 1'b0);
    step_plain(32'h504);
    expect_state("R2 advance in path", 32'h504, 32'hFFFF_0000, 1'b0);
    step_plain(32'h600);
    expect_state("R6 join restores mask", 32'h600, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_skip();
    step_branch(32'h0000_000F, 32'h700, 32'h800, 32'h800);
    expect_state("R7 only taken pushed", 32'h700, 32'h0000_000F, 1'b0);
    step_plain(32'h800);
    expect_state("R7 single pop to join", 32'h800, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_nested();
    step_branch(32'h00FF_00FF, 32'h1000, 32'h2000, 32'h3000);
    expect_state("R8 outer taken", 32'h1000, 32'h00FF_00FF, 1'b0);
    step_branch(32'h0000_00FF, 32'h1100, 32'h1200, 32'h1300);
    expect_state("R8 inner taken", 32'h1100, 32'h0000_00FF, 1'b0);
    step_plain(32'h1300);
    expect_state("R8 inner fall", 32'h1200, 32'h00FF_0000, 1'b0);
    step_plain(32'h1300);
    expect_state("R8 inner join", 32'h1300, 32'h00FF_00FF, 1'b0);
    step_plain(32'h3000);
    expect_state("R8 outer fall", 32'h2000, 32'hFF00_FF00, 1'b0);
    step_plain(32'h3000);
    expect_state("R8 outer join", 32'h3000, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_overflow();
    step_branch(32'h0000_FFFF, 32'hA000, 32'hA100, 32'hAF00);
    step_branch(32'h0000_00FF, 32'hB000, 32'hB100, 32'hBF00);
    step_branch(32'h0000_000F, 32'hC000, 32'hC100, 32'hCF00);
    expect_state("R8 three deep", 32'hC000, 32'h0000_000F, 1'b0);
    step_branch(32'h0000_0003, 32'hD000, 32'hD100, 32'hDF00);
    expect_state("R9 overflow flagged", 32'hC000, 32'h0000_000F, 1'b1);
    step_branch(32'h0000_0003, 32'hE000, 32'hEF00, 32'hEF00);
    expect_state("R9 fitting push proceeds", 32'hE000, 32'h0000_0003, 1'b1);
    step_plain(32'hE004);
    expect_state("R9 flag sticky", 32'hE004, 32'h0000_0003, 1'b1);
    do_reset();
    expect_state("R1 reset clears flag", 32'h100, 32'hFFFF_FFFF, 1'b0);
  endtask

  initial begin
    rstN = 1'b0;
    t_reset();
    t_plain();
    t_uniform();
    t_diverge();
    t_skip();
    t_nested();
    t_overflow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule